// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sends a 12-bit sample to a write-only serial DAC as one 16-bit frame. A one-cycle strobe on `new_data` while the block is idle captures the sample. The block then places a fixed 4-bit control nibble in front of the sample and loads the result into a shift register in a single cycle. It lowers the active-low select line and clocks the frame out most significant bit first, on a serial clock that is much slower than the system clock.

A free-running divider makes a one-cycle tick every `DIV` system clocks. The serial clock, the data line and the end-of-frame release of the select line change only on tick cycles. A small controller steps through three phases: waiting, shifting and releasing. The `busy` output tells the host when the next sample can be taken. Strobes that arrive while a frame is in progress are dropped.

Top module: `dac_frame_tx`

## Requirements
- R1: The frame sampled on the 16 rising edges of `sck` is {4'b0111, data[11:0]}. The control nibble comes first, starting with its bit 3, and data bit 0 comes last.
- R2: A `new_data` pulse while `busy` is low takes the sample at the next clock edge. From that edge, `cs_n` is 0 and `busy` is 1.
- R3: Each frame has exactly 16 rising edges of `sck` while `cs_n` is low, and `sck` is low whenever `cs_n` is high.
- R4: `sck` changes only on divider tick cycles. Each high phase lasts `DIV` system clocks and each full period lasts `2*DIV` system clocks.
- R5: `sdo` changes only while `sck` is low, and it holds its value across every rising edge of `sck`.
- R6: A `new_data` pulse while `busy` is high has no effect. The frame in progress keeps its original sample, and no second frame follows.
- R7: After the last bit, `cs_n` returns high and `busy` falls on the same edge, with `sck` low. Whenever `busy` is low, `cs_n` is high.
- R8: While `rst` is high, and right after it, `cs_n` is 1 and `sck`, `sdo` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| new_data | input | 1 | One-cycle strobe that offers a sample |
| data | input | 12 | Sample value, read on the accepted strobe |
| cs_n | output | 1 | Active-low DAC select |
| sck | output | 1 | Serial clock to the DAC |
| sdo | output | 1 | Serial data to the DAC, frame MSB first |
| busy | output | 1 | High from sample capture until the select line is released |

## Verification
The assertions assume that `new_data` is a clean synchronous pulse and that the host leaves `data` alone only on the capture cycle. The frame-length and edge-placement checks also assume that reset is not raised in the middle of a frame. The bench drives strobes at falling clock edges, so each strobe lasts exactly one cycle. During some frames it also changes `data` and fires stray strobes, which shows that the sample is only read when a frame is accepted.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic [1:0] {
    TX_WAIT  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_REL   = 2'd2
  } tx_phase_e;

endpackage

// File: rtl/dac_tick_div.sv
// Free-running divider: one-cycle tick every DIV system clocks.
module dac_tick_div #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] TOP = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == TOP) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = (cnt_q == TOP);
    end
  endgenerate

endmodule

// File: rtl/dac_frame_shreg.sv
// Parallel-load, left-shift register; MSB drives the serial line.
module dac_frame_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         msb
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (shift_en) begin
      sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end

  assign msb = sr_q[W-1];

endmodule

// File: rtl/dac_tx_ctrl.sv
// Phase controller: wait for strobe, shift 2*FRAME_W ticks, release select.
module dac_tx_ctrl
  import dac_tx_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic load,
  output logic shift_en,
  output logic sck,
  output logic cs_n,
  output logic busy
);

  localparam int NTICK = 2 * FRAME_W;
  localparam int CNT_W = $clog2(NTICK);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NTICK - 1);

  tx_phase_e      phase_q;
  logic [CNT_W-1:0] tcnt_q;

  assign load     = (phase_q == TX_WAIT) && start;
  assign shift_en = (phase_q == TX_SHIFT) && tick && tcnt_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= TX_WAIT;
      tcnt_q  <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
    end else begin
      unique case (phase_q)
        TX_WAIT: begin
          if (start) begin
            phase_q <= TX_SHIFT;
            tcnt_q  <= '0;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
          end
        end
        TX_SHIFT: begin
          if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == LAST) begin
              phase_q <= TX_REL;
              sck     <= 1'b0;
            end else begin
              sck <= ~tcnt_q[0];
            end
          end
        end
        TX_REL: begin
          if (tick) begin
            phase_q <= TX_WAIT;
            cs_n    <= 1'b1;
            busy    <= 1'b0;
          end
        end
        default: phase_q <= TX_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/dac_frame_tx.sv
// Top: joins control nibble and sample, drives select/clock/data to the DAC.
module dac_frame_tx #(
  parameter int          DATA_W = 12,
  parameter int          CMD_W  = 4,
  parameter logic [3:0]  CMD    = 4'b0111,
  parameter int          DIV    = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_data,
  input  logic [DATA_W-1:0] data,
  output logic              cs_n,
  output logic              sck,
  output logic              sdo,
  output logic              busy
);

  localparam int FRAME_W = CMD_W + DATA_W;

  logic               tick;
  logic               load;
  logic               shift_en;
  logic [FRAME_W-1:0] frame;

  assign frame = {CMD[CMD_W-1:0], data};

  dac_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dac_tx_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start    (new_data),
    .load     (load),
    .shift_en (shift_en),
    .sck      (sck),
    .cs_n     (cs_n),
    .busy     (busy)
  );

  dac_frame_shreg #(.W(FRAME_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (frame),
    .shift_en (shift_en),
    .msb      (sdo)
  );

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst,
  input logic new_data,
  input logic tick,
  input logic cs_n,
  input logic sck,
  input logic sdo,
  input logic busy
);

  logic       sck_q;
  logic [7:0] rises_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      rises_q <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n && !sck) begin
        rises_q <= '0;
      end else if (sck && !sck_q) begin
        rises_q <= rises_q + 1'b1;
      end
    end
  end

  AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!busy && new_data) |=> (busy && !cs_n));                       // R2

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);                                                  // R3

  AST_SIXTEEN_RISES: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rises_q == 8'(FRAME_W)));                       // R3

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck) |-> $past(tick));                                  // R4

  AST_SDO_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> !sck);                                         // R5

  AST_SDO_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(sdo));                                    // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck));                                       // R7

  AST_BUSY_DROP_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $rose(cs_n));                                    // R7

endmodule

bind dac_frame_tx dac_frame_tx_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .new_data (new_data),
  .tick     (tick),
  .cs_n     (cs_n),
  .sck      (sck),
  .sdo      (sdo),
  .busy     (busy)
);

// File: tb/dac_frame_tx_tb_top.sv
module dac_frame_tx_tb_top;

  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        new_data = 1'b0;
  logic [11:0] data = '0;
  logic        cs_n, sck, sdo, busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz with 1 ns units

  dac_frame_tx #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .new_data(new_data), .data(data),
    .cs_n(cs_n), .sck(sck), .sdo(sdo), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [11:0] d, input bit poke);
    logic [15:0] got = '0;
    logic [15:0] exp_frame;
    int cyc = 0, nrise = 0, last_rise = 0;
    bit prev_sck = 0, poked = 0, clr = 0;
    exp_frame = {4'b0111, d};
    @(negedge clk);
    while (busy) @(negedge clk);
    new_data = 1'b1;
    data = d;
    @(negedge clk);
    new_data = 1'b0;
    chk(cs_n == 1'b0 && busy == 1'b1, "R2 load", {30'd0, cs_n, busy}, 1);
    while (busy && cyc < 2000) begin
      if (clr) begin
        new_data = 1'b0;
        clr = 0;
      end
      if (sck && !prev_sck) begin
        got = {got[14:0], sdo};
        nrise++;
        if (nrise > 1) chk(cyc - last_rise == 2 * DIV, "R4 period", cyc - last_rise, 2 * DIV);
        last_rise = cyc;
      end
      if (!sck && prev_sck) chk(cyc - last_rise == DIV, "R4 high", cyc - last_rise, DIV);
      if (poke && !poked && nrise == 5) begin
        new_data = 1'b1;
        data = ~d;
        poked = 1;
        clr = 1;
      end
      prev_sck = sck;
      cyc++;
      @(negedge clk);
    end
    new_data = 1'b0;
    chk(got == exp_frame, poke ? "R6 frame kept" : "R1 frame", got, exp_frame);
    chk(nrise == 16, "R3 rises", nrise, 16);
    chk(cs_n == 1'b1 && sck == 1'b0, "R7 release", {30'd0, cs_n, sck}, 2);
    if (poke) begin
      repeat (4 * DIV) begin
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R6 no extra frame", {30'd0, busy, cs_n}, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 0 && sdo == 0 && busy == 0, "R8 in reset",
        {28'd0, cs_n, sck, sdo, busy}, 8);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 0 && sdo == 0 && busy == 0, "R8 after reset",
        {28'd0, cs_n, sck, sdo, busy}, 8);
    run_frame(12'h000, 0);
    run_frame(12'hFFF, 0);
    run_frame(12'hAAA, 1);
    run_frame(12'h555, 0);
    run_frame(12'h800, 1);
    run_frame(12'h001, 0);
    for (int i = 0; i < 12; i++) run_frame(12'(1 << i), 0);
    for (int i = 0; i < 12; i++) run_frame(~12'(1 << i), (i % 3) == 0);
    for (int i = 0; i < 40; i++) run_frame(12'((i * 331 + 7) % 4096), (i % 5) == 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule